// File: doc/BRIEF.md
# Two-Wire Bus Master Read Controller

This block is the master side of an I2C-style two-wire bus, reduced to read transfers from a slave with a 7-bit address. Software sets the slave address and the SCL half-period, then pulses a start command. The block then runs the whole read on the bus: the start condition, the address byte with the read bit, the check of the slave's acknowledge, the reception of the data bytes with the master's own acknowledges, and the closing stop condition.

The number of bytes is not programmed. It follows from when software pulses the stop command. A byte becomes the final one if a stop command is pending when that byte's first clock begins. The final byte gets a not-acknowledge from the master, and the stop condition follows it. So a stop pulsed together with the start gives a one-byte read. A stop pulsed after the next-to-last byte has arrived makes the next byte the final one.

Each received byte goes into a holding register and sets a ready flag. Reading that register clears the flag. If the next byte would begin while the flag is still set, the master keeps SCL low until the register is read, so no data is lost. Both bus lines are open-drain: an output of 1 pulls the line low, and the input reports the level on the wire.

Top module: `i2c_rd_master`

## Requirements
- R1: After reset the transfer-complete flag is 1, the ready and not-acknowledge flags are 0, and both lines are released (scl_oe = 0, sda_oe = 0).
- R2: A start command while idle clears the transfer-complete and not-acknowledge flags. SDA is pulled low while SCL is released (the start condition). Then 8 bits go out MSB first: the 7-bit slave address followed by a direction bit of 1.
- R3: Outside of holding, each SCL low phase and each SCL high phase lasts cfg_half system clock cycles (cfg_half >= 2). The high phase is counted only while the SCL input reads high.
- R4: On the 9th clock of the address byte the master releases SDA and samples it. If SDA is high, the not-acknowledge flag is set, no data byte is received, and the block issues a stop condition.
- R5: Data bits are sampled MSB first at the end of each SCL high phase. After the 8th bit the byte appears on rhr_data and rxrdy rises.
- R6: rxrdy returns to 0 on the clock edge that follows a cycle with rhr_read high.
- R7: The master drives SDA low on the 9th clock of every data byte except the final one. On the final byte it leaves SDA released (not-acknowledge) and then issues a stop condition.
- R8: A stop command given in the same cycle as the start command makes the first data byte the final one.
- R9: A stop command given after byte k has been received, and before the next byte begins, makes byte k+1 the final one.
- R10: If rxrdy is still set when the next data byte would begin, SCL is held low and rhr_data stays unchanged until rhr_read. The read then continues without loss.
- R11: SDA changes only while SCL is low, except for the start and stop conditions. Transfer-complete rises once SDA has been released after SCL in the stop condition, and stays 1 with both lines released until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | DIV_W | SCL half-period in clock cycles (>= 2) |
| slave_addr | input | DATA_W-1 | 7-bit slave address |
| cmd_start | input | 1 | One-cycle start command |
| cmd_stop | input | 1 | One-cycle stop command |
| rhr_read | input | 1 | One-cycle read strobe of the holding register |
| rhr_data | output | DATA_W | Receive holding register |
| rxrdy | output | 1 | Received byte waiting in the holding register |
| nack | output | 1 | Address not acknowledged |
| txcomp | output | 1 | Transfer complete / idle |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | SCL level on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA level on the wire |

## Verification
The assertions check on every cycle the properties that are local in time. SDA may move while SCL is high only as a start or a stop, and a start always coincides with transfer-complete falling. An idle block keeps both lines released. The ready flag drops after a read. A waiting byte stays frozen until it is read, and an address not-acknowledge is followed at once by SCL pulled low. Only the bench scenarios show the behaviours that span a whole transfer: the byte values, the acknowledge pattern, the transfer length set by the moment of the stop command, the phase lengths, and the SCL hold while software is slow. For these the bench uses a slave model on the wires.

// File: rtl/i2cr_pkg.sv
`timescale 1ns/1ps
package i2cr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LOW,
    ST_HIGH,
    ST_WAIT,
    ST_STOP_LOW,
    ST_STOP_HIGH,
    ST_STOP_END
  } seq_state_t;
endpackage

// File: rtl/i2cr_phase_timer.sv
`timescale 1ns/1ps
// Counts one bus half-phase; tick marks its last cycle.
module i2cr_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cr_rx_hold.sv
`timescale 1ns/1ps
// Receive holding register with its ready flag.
module i2cr_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] data,
  output logic              ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      ready <= 1'b0;
    end else if (push) begin
      data  <= push_data;
      ready <= 1'b1;
    end else if (pop) begin
      ready <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cr_seq.sv
`timescale 1ns/1ps
// Bus sequencer: start, address, data bytes, acknowledges, stop.
module i2cr_seq
  import i2cr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic [DATA_W-2:0] slave_addr,
  input  logic              tick,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              rxrdy,
  output logic              run,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              nack,
  output logic              txcomp
);
  localparam int FRAME = DATA_W + 1;
  localparam int BIT_W = $clog2(FRAME + 1);

  seq_state_t        st;
  logic [DATA_W-1:0] shreg;
  logic [BIT_W-1:0]  bitn;
  logic              is_addr;
  logic              last;
  logic              stop_pend;
  logic              ack_slot;
  logic              drive;
  logic [DATA_W-1:0] sampled;

  assign ack_slot = (bitn == BIT_W'(DATA_W));
  assign sampled  = {shreg[DATA_W-2:0], sda_in};

  always_comb begin
    if (ack_slot) drive = !is_addr && !last;
    else          drive = is_addr && !shreg[DATA_W-1];
  end

  always_comb begin
    run = (st != ST_IDLE) && (st != ST_WAIT);
    if ((st == ST_HIGH || st == ST_STOP_HIGH) && !scl_in) run = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      shreg     <= '0;
      bitn      <= '0;
      is_addr   <= 1'b0;
      last      <= 1'b0;
      stop_pend <= 1'b0;
      nack      <= 1'b0;
      txcomp    <= 1'b1;
      push      <= 1'b0;
      push_data <= '0;
    end else begin
      push <= 1'b0;
      if (cmd_stop && st != ST_IDLE) stop_pend <= 1'b1;
      case (st)
        ST_IDLE: if (cmd_start) begin
          st        <= ST_START;
          sda_oe    <= 1'b1;
          shreg     <= {slave_addr, 1'b1};
          bitn      <= '0;
          is_addr   <= 1'b1;
          nack      <= 1'b0;
          txcomp    <= 1'b0;
          stop_pend <= cmd_stop;
        end
        ST_START: if (tick) begin
          scl_oe <= 1'b1;
          st     <= ST_LOW;
        end
        ST_LOW: begin
          sda_oe <= drive;
          if (tick) begin
            scl_oe <= 1'b0;
            st     <= ST_HIGH;
          end
        end
        ST_HIGH: if (tick) begin
          scl_oe <= 1'b1;
          if (!ack_slot) begin
            shreg <= sampled;
            bitn  <= bitn + 1'b1;
            st    <= ST_LOW;
            if (!is_addr && bitn == BIT_W'(DATA_W - 1)) begin
              push      <= 1'b1;
              push_data <= sampled;
            end
          end else if (is_addr ? sda_in : last) begin
            if (is_addr) nack <= 1'b1;
            st <= ST_STOP_LOW;
          end else begin
            is_addr <= 1'b0;
            bitn    <= '0;
            if (rxrdy) st <= ST_WAIT;
            else begin
              last <= stop_pend || cmd_stop;
              st   <= ST_LOW;
            end
          end
        end
        ST_WAIT: begin
          sda_oe <= 1'b0;
          if (!rxrdy) begin
            last <= stop_pend || cmd_stop;
            st   <= ST_LOW;
          end
        end
        ST_STOP_LOW: begin
          sda_oe <= 1'b1;
          if (tick) begin
            scl_oe <= 1'b0;
            st     <= ST_STOP_HIGH;
          end
        end
        ST_STOP_HIGH: if (tick) begin
          sda_oe <= 1'b0;
          st     <= ST_STOP_END;
        end
        ST_STOP_END: if (tick) begin
          txcomp    <= 1'b1;
          stop_pend <= 1'b0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rd_master.sv
`timescale 1ns/1ps
module i2c_rd_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [DATA_W-2:0] slave_addr,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              rhr_read,
  output logic [DATA_W-1:0] rhr_data,
  output logic              rxrdy,
  output logic              nack,
  output logic              txcomp,
  output logic              scl_oe,
  input  logic              scl_in,
  output logic              sda_oe,
  input  logic              sda_in
);
  logic              run;
  logic              tick;
  logic              push;
  logic [DATA_W-1:0] push_data;

  i2cr_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .limit (cfg_half),
    .tick  (tick)
  );

  i2cr_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_start  (cmd_start),
    .cmd_stop   (cmd_stop),
    .slave_addr (slave_addr),
    .tick       (tick),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .rxrdy      (rxrdy),
    .run        (run),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .push       (push),
    .push_data  (push_data),
    .nack       (nack),
    .txcomp     (txcomp)
  );

  i2cr_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (push_data),
    .pop       (rhr_read),
    .data      (rhr_data),
    .ready     (rxrdy)
  );
endmodule

// File: rtl/i2cr_checker.sv
`timescale 1ns/1ps
module i2cr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rhr_read,
  input logic [DATA_W-1:0] rhr_data,
  input logic              rxrdy,
  input logic              nack,
  input logic              txcomp,
  input logic              scl_oe,
  input logic              sda_oe
);
  AST_START_FORM: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && !scl_oe && !$past(scl_oe)) |-> $fell(txcomp)); // R2

  AST_SDA_ONLY_LOW: assert property (@(posedge clk) disable iff (rst)
    ($changed(sda_oe) && !$past(scl_oe) && !$fell(sda_oe)) |-> $fell(txcomp)); // R11

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    txcomp |-> (!scl_oe && !sda_oe)); // R11

  AST_NACK_STOPS: assert property (@(posedge clk) disable iff (rst)
    $rose(nack) |-> (scl_oe && !txcomp)); // R4

  AST_RXRDY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rxrdy && rhr_read) |=> !rxrdy); // R6

  AST_HOLD_NO_LOSS: assert property (@(posedge clk) disable iff (rst)
    (rxrdy && !rhr_read) |=> (rxrdy && $stable(rhr_data))); // R10
endmodule

bind i2c_rd_master i2cr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rhr_read (rhr_read),
  .rhr_data (rhr_data),
  .rxrdy    (rxrdy),
  .nack     (nack),
  .txcomp   (txcomp),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe)
);

// File: tb/i2c_rd_master_bench.sv
`timescale 1ns/1ps
module i2c_rd_master_bench;
  localparam logic [6:0] SLV_ADDR = 7'h52;
  localparam int NVEC = 5;
  // {addr[6:0], nbytes[3:0], half[7:0], seed[7:0], delay[7:0]}
  localparam logic [34:0] VECS [0:NVEC-1] = '{
    {7'h52, 4'd3, 8'd4, 8'h5A, 8'd0},
    {7'h52, 4'd1, 8'd3, 8'hC3, 8'd0},
    {7'h52, 4'd5, 8'd6, 8'h01, 8'd0},
    {7'h21, 4'd2, 8'd5, 8'h00, 8'd0},
    {7'h52, 4'd2, 8'd2, 8'hFF, 8'd60}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_half = 8'd4;
  logic [6:0] slave_addr = SLV_ADDR;
  logic       cmd_start = 1'b0;
  logic       cmd_stop = 1'b0;
  logic       rhr_read = 1'b0;
  logic [7:0] rhr_data;
  logic       rxrdy, nack, txcomp, scl_oe, sda_oe;
  logic       scl_in, sda_in;
  logic       s_oe;

  assign scl_in = ~scl_oe;
  assign sda_in = ~(sda_oe | s_oe);

  always #2.5 clk = ~clk;

  i2c_rd_master u_i2c_rd_master (
    .clk(clk), .rst(rst), .cfg_half(cfg_half), .slave_addr(slave_addr),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .rhr_read(rhr_read),
    .rhr_data(rhr_data), .rxrdy(rxrdy), .nack(nack), .txcomp(txcomp),
    .scl_oe(scl_oe), .scl_in(scl_in), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  function automatic logic [7:0] exp_byte(input logic [7:0] s, input int k);
    return s + 8'(k * 59);
  endfunction

  // ---------------- slave model on the wires ----------------
  logic [7:0] cur_seed = 8'h00;
  logic       pscl, psda, s_active, s_addr_ph, s_last_ack;
  logic [7:0] rx_sh, tx, got_addr;
  int         bitc, byte_k, starts, stops, macks, mnacks;
  int         hi_run, lo_run, hi_last, lo_last, nb;
  logic [7:0] nx;

  always @(posedge clk) begin
    pscl <= scl_in;
    psda <= sda_in;
    if (rst) begin
      s_active <= 1'b0; s_oe <= 1'b0; s_addr_ph <= 1'b1; bitc <= -1;
      starts <= 0; stops <= 0; macks <= 0; mnacks <= 0;
      hi_run <= 0; lo_run <= 0; hi_last <= 0; lo_last <= 0;
      byte_k <= 0; s_last_ack <= 1'b0; rx_sh <= '0; tx <= '0; got_addr <= '0;
    end else begin
      hi_run <= scl_in ? hi_run + 1 : 0;
      lo_run <= scl_in ? 0 : lo_run + 1;
      if (pscl && scl_in && psda && !sda_in) begin
        starts <= starts + 1; s_active <= 1'b1; s_addr_ph <= 1'b1;
        bitc <= -1; s_oe <= 1'b0;
      end else if (pscl && scl_in && !psda && sda_in) begin
        stops <= stops + 1; s_active <= 1'b0; s_oe <= 1'b0;
      end else if (s_active) begin
        if (!pscl && scl_in) begin
          if (!s_addr_ph && bitc >= 1 && bitc <= 7) lo_last <= lo_run;
          if (bitc < 8) rx_sh <= {rx_sh[6:0], sda_in};
          else if (!s_addr_ph) begin
            if (sda_in) mnacks <= mnacks + 1; else macks <= macks + 1;
            s_last_ack <= !sda_in;
          end
        end
        if (pscl && !scl_in) begin
          if (!s_addr_ph) hi_last <= hi_run;
          if (bitc == 8) begin
            if (s_addr_ph) begin
              got_addr <= rx_sh;
              if (s_oe) begin
                nx = exp_byte(cur_seed, 0);
                s_addr_ph <= 1'b0; byte_k <= 0; tx <= nx; bitc <= 0; s_oe <= !nx[7];
              end else begin
                s_active <= 1'b0; s_oe <= 1'b0;
              end
            end else if (s_last_ack) begin
              nx = exp_byte(cur_seed, byte_k + 1);
              byte_k <= byte_k + 1; tx <= nx; bitc <= 0; s_oe <= !nx[7];
            end else begin
              s_oe <= 1'b0; s_active <= 1'b0;
            end
          end else begin
            nb = bitc + 1;
            bitc <= nb;
            if (s_addr_ph) s_oe <= (nb == 8) && (rx_sh[7:1] == SLV_ADDR) && rx_sh[0];
            else           s_oe <= (nb < 8) ? !tx[7-nb] : 1'b0;
          end
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic wait_flag_rx();
    while (!rxrdy) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!txcomp) @(negedge clk);
  endtask

  task automatic run_vec(input logic [34:0] v);
    logic [6:0] addr;
    int n, half, dly, s0, p0, a0, m0;
    logic [7:0] seed;
    bit present;
    addr = v[34:28]; n = int'(v[27:24]); half = int'(v[23:16]);
    seed = v[15:8]; dly = int'(v[7:0]);
    present = (addr == SLV_ADDR);
    cur_seed = seed; cfg_half = 8'(half); slave_addr = addr;
    s0 = starts; p0 = stops; a0 = macks; m0 = mnacks;
    @(negedge clk);
    cmd_start = 1'b1; cmd_stop = (n == 1);
    @(negedge clk);
    cmd_start = 1'b0; cmd_stop = 1'b0;
    chk(!txcomp, "R2 txcomp cleared by start", txcomp, 0);
    if (present) begin
      for (int k = 0; k < n; k++) begin
        wait_flag_rx();
        if (k == n - 2) begin
          cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;   // R9
        end
        if (dly > 0 && k < n - 1) begin
          repeat (dly) @(negedge clk);
          chk(scl_oe == 1'b1, "R10 SCL held low", scl_oe, 1);
          chk(rxrdy == 1'b1, "R10 rxrdy kept", rxrdy, 1);
        end
        chk(rhr_data == exp_byte(seed, k), "R5 data byte", rhr_data, exp_byte(seed, k));
        rhr_read = 1'b1; @(negedge clk); rhr_read = 1'b0;
        if (k == 0) chk(rxrdy == 1'b0, "R6 rxrdy cleared by read", rxrdy, 0);
      end
    end
    wait_done();
    @(negedge clk);
    chk(got_addr == {addr, 1'b1}, "R2 address byte with read bit", got_addr, {addr, 1'b1});
    chk(starts - s0 == 1, "R2 one start condition", starts - s0, 1);
    chk(nack == !present, "R4 nack flag", nack, !present);
    chk(stops - p0 == 1, "R11 one stop condition", stops - p0, 1);
    chk(!scl_oe && !sda_oe, "R11 lines released when complete", {scl_oe, sda_oe}, 0);
    if (present) begin
      if (n == 1) chk(macks - a0 == 0 && mnacks - m0 == 1, "R8 single byte ends with nack",
                      macks - a0, 0);
      else        chk(macks - a0 == n - 1, "R9 stop after next-to-last: ack count",
                      macks - a0, n - 1);
      chk(mnacks - m0 == 1, "R7 final byte nacked", mnacks - m0, 1);
      chk(hi_last == half, "R3 SCL high phase", hi_last, half);
      if (n > 1) chk(lo_last == half, "R3 SCL low phase", lo_last, half);
    end else begin
      chk(rxrdy == 1'b0, "R4 no data after address nack", rxrdy, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txcomp == 1'b1, "R1 txcomp after reset", txcomp, 1);
    chk(rxrdy == 1'b0, "R1 rxrdy after reset", rxrdy, 0);
    chk(nack == 1'b0, "R1 nack after reset", nack, 0);
    chk(!scl_oe && !sda_oe, "R1 lines released after reset", {scl_oe, sda_oe}, 0);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // directed: reset in the middle of a read
    cfg_half = 8'd4; slave_addr = SLV_ADDR; cur_seed = 8'h77;
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0; @(negedge clk);
    chk(txcomp == 1'b1 && rxrdy == 1'b0 && nack == 1'b0, "R1 flags after mid-read reset",
        {txcomp, rxrdy, nack}, 3'b100);
    chk(!scl_oe && !sda_oe, "R1 lines after mid-read reset", {scl_oe, sda_oe}, 0);

    // directed: new read after reset still works (single byte)
    run_vec({7'h52, 4'd1, 8'd2, 8'h80, 8'd0});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule